// File: doc/BRIEF.md
# Key-Gated Access Lock

This block sits in front of a protected storage controller. It decides whether read, write, verify and erase requests may pass. A 128-bit secret is kept in a register of its own, apart from the data store. The guard starts locked. While it is locked, every guarded request is answered with an error strobe and never reaches storage. An unlock command opens the guard, but only if it carries a key equal to the stored secret in every bit. The guard stays open until a relock command or a reset.

While the guard is open, software can replace the secret. It writes four 32-bit words into a staging area and then issues a commit command. A seal command makes the protection permanent. Sealing locks the guard and from then on refuses every unlock, commit, staging write and further seal. The sealed flag and the stored secret model non-volatile cells, so a reset does not clear them. They take their values once, at power-up, and a reset only re-engages the lock.

Top module: `access_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `locked` is 1 and `op_grant` and `op_err` are 0. At power-up `sealed` is 0.
- R2: A guarded request sent while locked gives `op_err`=1 and `op_grant`=0 in the cycle after the request. A guarded request is `cmd_op` 0 (read), 1 (write), 2 (verify) or 3 (erase).
- R3: A guarded request sent while unlocked gives `op_grant`=1, `op_err`=0, and `op_kind` equal to the request's low two `cmd_op` bits, in the cycle after the request.
- R4: An unlock (`cmd_op`=4) whose `key_in` equals the stored key in all 128 bits clears `locked` with no error. A key that differs in any bit gives `op_err`=1 and leaves the guard locked.
- R5: A relock (`cmd_op`=5) sets `locked` without raising `op_err`.
- R6: While unlocked and not sealed, a staging write with `kw_valid` stores `kw_data` as word `kw_idx`, where word 0 is key bits 31:0. A commit (`cmd_op`=6) then replaces the stored key with the four staged words. A staging write or commit sent while locked raises `op_err` and leaves the stored key unchanged.
- R7: A seal (`cmd_op`=7) sent while unlocked sets `sealed` and `locked` with no error. Once sealed, every unlock, commit, seal and staging write raises `op_err`, and the guard stays locked.
- R8: At power-up the stored key equals the parameter `INIT_KEY`. Reset changes neither the key nor `sealed`.
- R9: `op_grant` and `op_err` are registered one-cycle strobes. An idle cycle after a request brings both back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; re-engages the lock |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 read, 1 write, 2 verify, 3 erase, 4 unlock, 5 relock, 6 commit, 7 seal) |
| key_in | input | KEY_W (128) | Key offered with an unlock command |
| kw_valid | input | 1 | Staging word write strobe |
| kw_idx | input | IDX_W (2) | Staging word index |
| kw_data | input | WORD_W (32) | Staging word value |
| op_grant | output | 1 | Guarded request admitted (one cycle) |
| op_kind | output | 2 | Class of the admitted request |
| op_err | output | 1 | Request refused (one cycle) |
| locked | output | 1 | Guard engaged |
| sealed | output | 1 | Permanent protection set |

## Verification
Some properties are checked by assertions on every cycle. A grant is never paired with an error, and no grant follows a cycle in which the guard was locked. The lock only drops after an unlock whose key matched. The sealed flag never clears, and it always implies the lock. The stored key cannot change without a commit, or at all once sealed. Other behaviour only the directed scenarios can show. These include the 128-bit compare rejecting keys that differ in a single edge bit, the staging word order, an old key failing after a new one is committed, and the seal and key surviving a reset.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_VERIFY = 3'd2,
    OP_ERASE  = 3'd3,
    OP_UNLOCK = 3'd4,
    OP_RELOCK = 3'd5,
    OP_COMMIT = 3'd6,
    OP_SEAL   = 3'd7
  } guard_op_e;
endpackage

// File: rtl/key_vault.sv
module key_vault #(
  parameter int KEY_W = 128,
  parameter int WORD_W = 32,
  parameter logic [KEY_W-1:0] INIT_KEY = '0,
  localparam int NWORDS = KEY_W / WORD_W,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_we,
  input  logic [IDX_W-1:0]  stage_idx,
  input  logic [WORD_W-1:0] stage_data,
  input  logic              commit,
  input  logic              sealed_i,
  input  logic [KEY_W-1:0]  probe_key,
  output logic              match
);
  logic [WORD_W-1:0] stage_q [NWORDS];
  logic [KEY_W-1:0]  staged;
  logic [KEY_W-1:0]  key_q = INIT_KEY;

  always_ff @(posedge clk) begin
    if (stage_we) stage_q[stage_idx] <= stage_data;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_pack
    assign staged[g*WORD_W +: WORD_W] = stage_q[g];
  end

  // Non-volatile model: the key is loaded at power-up and reset leaves it alone
  always_ff @(posedge clk) begin
    if (commit) key_q <= staged;
  end

  assign match = (probe_key == key_q);

  a_r6_key_needs_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(key_q));
  a_r7_key_frozen: assert property (@(posedge clk) disable iff (rst)
    sealed_i |=> $stable(key_q));
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_valid,
  input  guard_op_e cmd_op,
  input  logic      kw_valid,
  input  logic      match,
  output logic      locked_o,
  output logic      sealed_o,
  output logic      stage_we,
  output logic      commit_o,
  output logic      pass_o,
  output logic      fail_o
);
  logic locked_q = 1'b1;
  logic sealed_q = 1'b0;
  logic locked_n, sealed_n, cmd_bad, open;

  assign open = !locked_q;

  always_comb begin
    locked_n = locked_q;
    sealed_n = sealed_q;
    cmd_bad  = 1'b0;
    commit_o = 1'b0;
    pass_o   = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        OP_READ, OP_WRITE, OP_VERIFY, OP_ERASE: begin
          pass_o  = open;
          cmd_bad = !open;
        end
        OP_UNLOCK: begin
          if (!sealed_q && match) locked_n = 1'b0;
          else begin
            cmd_bad  = 1'b1;
            locked_n = 1'b1;
          end
        end
        OP_RELOCK: locked_n = 1'b1;
        OP_COMMIT: begin
          commit_o = open;
          cmd_bad  = !open;
        end
        OP_SEAL: begin
          if (open) begin
            sealed_n = 1'b1;
            locked_n = 1'b1;
          end else cmd_bad = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign stage_we = kw_valid && open;
  assign fail_o   = cmd_bad || (kw_valid && !open);

  always_ff @(posedge clk) begin
    if (rst) locked_q <= 1'b1;
    else     locked_q <= locked_n;
  end

  // Sealed flag models a one-time-programmable cell: no reset
  always_ff @(posedge clk) begin
    if (!rst) sealed_q <= sealed_n;
  end

  assign locked_o = locked_q;
  assign sealed_o = sealed_q;

  a_r7_seal_sticky: assert property (@(posedge clk) disable iff (rst)
    sealed_q |=> sealed_q);
  a_r7_sealed_locked: assert property (@(posedge clk) disable iff (rst)
    sealed_q |-> locked_q);
endmodule

// File: rtl/op_gate.sv
module op_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       pass_i,
  input  logic       fail_i,
  input  logic [1:0] kind_i,
  output logic       grant_o,
  output logic [1:0] kind_o,
  output logic       err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      err_o   <= 1'b0;
      kind_o  <= '0;
    end else begin
      grant_o <= pass_i;
      err_o   <= fail_i;
      if (pass_i) kind_o <= kind_i;
    end
  end

  a_r3_grant_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && err_o));
endmodule

// File: rtl/access_guard.sv
module access_guard
  import guard_pkg::*;
#(
  parameter int KEY_W = 128,
  parameter int WORD_W = 32,
  parameter logic [KEY_W-1:0] INIT_KEY = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
  localparam int NWORDS = KEY_W / WORD_W,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              kw_valid,
  input  logic [IDX_W-1:0]  kw_idx,
  input  logic [WORD_W-1:0] kw_data,
  output logic              op_grant,
  output logic [1:0]        op_kind,
  output logic              op_err,
  output logic              locked,
  output logic              sealed
);
  logic match, stage_we, commit, pass, fail;
  guard_op_e op;

  assign op = guard_op_e'(cmd_op);

  key_vault #(.KEY_W(KEY_W), .WORD_W(WORD_W), .INIT_KEY(INIT_KEY)) u_vault (
    .clk(clk), .rst(rst), .stage_we(stage_we), .stage_idx(kw_idx),
    .stage_data(kw_data), .commit(commit), .sealed_i(sealed),
    .probe_key(key_in), .match(match)
  );

  lock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op),
    .kw_valid(kw_valid), .match(match), .locked_o(locked), .sealed_o(sealed),
    .stage_we(stage_we), .commit_o(commit), .pass_o(pass), .fail_o(fail)
  );

  op_gate u_gate (
    .clk(clk), .rst(rst), .pass_i(pass), .fail_i(fail), .kind_i(cmd_op[1:0]),
    .grant_o(op_grant), .kind_o(op_kind), .err_o(op_err)
  );

  a_r2_grant_needs_open: assert property (@(posedge clk) disable iff (rst)
    op_grant |-> !$past(locked));
  a_r4_unlock_needs_match: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(cmd_valid && cmd_op == 3'd4 && match));
endmodule

// File: tb/test_access_guard.sv
module test_access_guard;
  localparam logic [127:0] K0 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] K1 = 128'hA5A5_0F0F_1234_5678_DEAD_BEEF_CAFE_F00D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [127:0] key_in = '0;
  logic kw_valid = 1'b0;
  logic [1:0] kw_idx = '0;
  logic [31:0] kw_data = '0;
  logic op_grant, op_err, locked, sealed;
  logic [1:0] op_kind;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  access_guard i_access_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .key_in(key_in),
    .kw_valid(kw_valid), .kw_idx(kw_idx), .kw_data(kw_data), .op_grant(op_grant),
    .op_kind(op_kind), .op_err(op_err), .locked(locked), .sealed(sealed)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge
  task automatic send(input logic [2:0] op, input logic [127:0] k);
    cmd_valid = 1'b1; cmd_op = op; key_in = k;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stage(input logic [1:0] idx, input logic [31:0] d);
    kw_valid = 1'b1; kw_idx = idx; kw_data = d;
    @(negedge clk);
    kw_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 locked after reset", locked, 1);
    chk("R1 grant low", op_grant, 0);
    chk("R1 err low", op_err, 0);
    chk("R1 not sealed at power-up", sealed, 0);
  endtask

  task automatic t_locked_ops();
    for (int i = 0; i < 4; i++) begin
      send(i[2:0], '0);
      chk("R2 err while locked", op_err, 1);
      chk("R2 no grant while locked", op_grant, 0);
    end
    idle();
    chk("R9 err strobe clears", op_err, 0);
  endtask

  task automatic t_bad_key();
    send(3'd4, K0 ^ 128'd1);
    chk("R4 bit0 mismatch err", op_err, 1);
    chk("R4 bit0 mismatch locked", locked, 1);
    send(3'd4, K0 ^ (128'd1 << 127));
    chk("R4 bit127 mismatch err", op_err, 1);
    chk("R4 bit127 mismatch locked", locked, 1);
  endtask

  task automatic t_unlock();
    send(3'd4, K0);
    chk("R8 initial key unlocks", locked, 0);
    chk("R4 good key no err", op_err, 0);
  endtask

  task automatic t_ops_open();
    for (int i = 0; i < 4; i++) begin
      send(i[2:0], '0);
      chk("R3 grant while open", op_grant, 1);
      chk("R3 kind", op_kind, i[1:0]);
      chk("R3 no err", op_err, 0);
    end
    idle();
    chk("R9 grant strobe clears", op_grant, 0);
  endtask

  task automatic t_relock();
    send(3'd5, '0);
    chk("R5 relock locks", locked, 1);
    chk("R5 relock no err", op_err, 0);
    send(3'd0, '0);
    chk("R5 read refused after relock", op_err, 1);
  endtask

  task automatic t_key_load();
    send(3'd4, K0);
    for (int w = 0; w < 4; w++) begin
      stage(w[1:0], K1[w*32 +: 32]);
      chk("R6 staging write no err", op_err, 0);
    end
    send(3'd6, '0);
    chk("R6 commit no err", op_err, 0);
    send(3'd5, '0);
    send(3'd4, K0);
    chk("R6 old key rejected", locked, 1);
    send(3'd4, K1);
    chk("R6 new key unlocks", locked, 0);
  endtask

  task automatic t_locked_load();
    send(3'd5, '0);
    stage(2'd0, 32'h0);
    chk("R6 staging refused while locked", op_err, 1);
    send(3'd6, '0);
    chk("R6 commit refused while locked", op_err, 1);
    send(3'd4, K1);
    chk("R6 key unchanged after refused load", locked, 0);
  endtask

  task automatic t_seal();
    send(3'd7, '0);
    chk("R7 seal sets sealed", sealed, 1);
    chk("R7 seal locks", locked, 1);
    chk("R7 seal no err", op_err, 0);
    send(3'd4, K1);
    chk("R7 unlock refused", op_err, 1);
    chk("R7 stays locked", locked, 1);
    send(3'd6, '0);
    chk("R7 commit refused", op_err, 1);
    stage(2'd1, 32'h0);
    chk("R7 staging refused", op_err, 1);
    send(3'd7, '0);
    chk("R7 reseal refused", op_err, 1);
    send(3'd3, '0);
    chk("R7 erase refused", op_err, 1);
  endtask

  task automatic t_reset_persist();
    do_reset();
    chk("R8 sealed survives reset", sealed, 1);
    chk("R1 locked after reset", locked, 1);
    send(3'd4, K1);
    chk("R7 unlock refused after reset", op_err, 1);
    chk("R7 locked after reset", locked, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_locked_ops();
    t_bad_key();
    t_unlock();
    t_ops_open();
    t_relock();
    t_key_load();
    t_locked_load();
    t_seal();
    t_reset_persist();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule